// File: doc/BRIEF.md
# Signed Radix-4 Recoded Multiplier with Selectable Pipeline

This block multiplies two signed two's-complement integers of independent widths and returns the full-width signed product, wide enough that no input pair can overflow it. It is built only from plain logic and uses no multiply operator. The multiplier operand is recoded into radix-4 signed digits in the set {-2, -1, 0, +1, +2}, so each digit picks one partial-product row. When that width is odd, the operand is first sign-extended to an even width. A negative digit inverts its row, and the matching +1 is gathered into one extra correction row.

All rows, sign-extended to the product width, go into a tree of 3:2 carry-save compressors. The tree reduces them level by level until two words remain. A Brent-Kung parallel-prefix adder sums the two words. The `STAGES` parameter sets the latency. At 0 the block is purely combinational. At 1 a register bank sits between the tree and the adder. At 2 a second bank also holds the product output. A synchronous reset clears every bank.

Top module: `booth_mul`

## Requirements
- R1: For any operands, `prod` equals the signed product `a_in * b_in` in `A_W + B_W` bits. The two carry-save words sum to this value modulo 2^(A_W+B_W), and the prefix adder returns their exact sum.
- R2: The extreme operand pairs give exact results: most-negative times most-negative (a positive value of 2^(A_W+B_W-2)), most-negative times most-positive, and most-positive times most-positive.
- R3: A zero operand gives a product of 0. An operand of -1 gives the two's-complement negation of the other operand.
- R4: When `B_W` is odd (the default is 9), bit `B_W-1` of `b_in` carries the negative weight -2^(B_W-1). Examples: `b_in` = 9'h100 is -256, 9'h1FF is -1, and 9'h0FF is +255.
- R5: The product for operands applied before a rising clock edge appears after exactly `STAGES` rising edges, where `STAGES` is 0, 1 or 2. Operands that change on every cycle produce one distinct, correct product per cycle.
- R6: With `STAGES` of 1 or 2, a rising edge with `rst` high clears the pipeline registers, so `prod` reads 0 after that edge for as long as reset is held, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | A_W | Multiplicand, signed two's complement |
| b_in | input | B_W | Multiplier (recoded operand), signed two's complement |
| prod | output | A_W+B_W | Signed product |

## Verification
The combinational variant's product is due in the same cycle as its operands. The one- and two-stage variants deliver theirs one and two rising edges later. The bench drives a new operand pair on each falling edge and checks the combinational instance 1 ns later. At the next falling edge, before it drives new operands, it checks the registered instances against a two-deep history of expected products. That history is marked invalid at every reset, so no check ever compares against a product the pipeline has not yet been fed. The reset checks sample after a rising edge taken with reset high and nonzero operands.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  // Selection produced by one radix-4 digit
  typedef struct packed {
    logic neg;   // digit is negative
    logic one;   // magnitude 1
    logic two;   // magnitude 2
  } booth_sel_t;

  // Recode the overlapping triple {b[2i+1], b[2i], b[2i-1]}
  function automatic booth_sel_t booth_decode(input logic [2:0] grp);
    booth_sel_t s;
    s.one = grp[1] ^ grp[0];
    s.two = (grp[2] & ~grp[1] & ~grp[0]) | (~grp[2] & grp[1] & grp[0]);
    s.neg = grp[2] & ~(grp[1] & grp[0]);
    return s;
  endfunction

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_mul_pkg::*;
#(
  parameter int A_W  = 12,
  parameter int B_W  = 9,
  localparam int W    = A_W + B_W,
  localparam int BE   = B_W + (B_W % 2),
  localparam int NPP  = BE / 2,
  localparam int ROWS = NPP + 1
) (
  input  logic [A_W-1:0]             a_in,
  input  logic [B_W-1:0]             b_in,
  output logic [ROWS-1:0][W-1:0]     rows
);

  logic [W-1:0]  a_ext;
  logic [W-1:0]  a_dbl;
  logic [BE-1:0] b_ext;
  logic [BE:0]   b_grp;   // b_ext with a zero below bit 0
  logic [W-1:0]  corr;    // +1 injections for negated rows

  assign a_ext = W'($signed(a_in));
  assign a_dbl = a_ext << 1;
  assign b_ext = BE'($signed(b_in));
  assign b_grp = {b_ext, 1'b0};

  for (genvar i = 0; i < NPP; i++) begin : g_digit
    booth_sel_t   sel;
    logic [W-1:0] mag;
    assign sel = booth_decode(b_grp[2*i+2 : 2*i]);
    assign mag = sel.one ? a_ext : (sel.two ? a_dbl : '0);
    assign rows[i] = (sel.neg ? ~mag : mag) << (2*i);
    assign corr[2*i]   = sel.neg;
    assign corr[2*i+1] = 1'b0;
  end

  assign corr[W-1:BE] = '0;
  assign rows[NPP]    = corr;

endmodule

// File: rtl/csa_tree.sv
module csa_tree #(
  parameter int W    = 21,
  parameter int ROWS = 6
) (
  input  logic [ROWS-1:0][W-1:0] rows_in,
  output logic [W-1:0]           sum_w,
  output logic [W-1:0]           carry_w
);

  localparam int NGRP = ROWS / 3;

  logic [ROWS-1:0][W-1:0] cur;
  logic [ROWS-1:0][W-1:0] nxt;

  // Each level replaces every full group of three rows by a sum row and a
  // carry row (one full adder per bit); leftover rows pass to the next level.
  always_comb begin
    int cnt;
    int ng;
    int rm;
    cur = rows_in;
    nxt = '0;
    cnt = ROWS;
    for (int l = 0; l < ROWS; l++) begin
      if (cnt > 2) begin
        ng  = cnt / 3;
        rm  = cnt % 3;
        nxt = '0;
        for (int g = 0; g < NGRP; g++) begin
          if (g < ng) begin
            nxt[2*g]   = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
            nxt[2*g+1] = ((cur[3*g] & cur[3*g+1]) | (cur[3*g] & cur[3*g+2]) |
                          (cur[3*g+1] & cur[3*g+2])) << 1;
          end
        end
        for (int k = 0; k < 2; k++) begin
          if (k < rm) nxt[2*ng+k] = cur[3*ng+k];
        end
        cur = nxt;
        cnt = 2*ng + rm;
      end
    end
  end

  assign sum_w   = cur[0];
  assign carry_w = cur[1];

endmodule

// File: rtl/bk_adder.sv
module bk_adder #(
  parameter int W = 21,
  localparam int LOG = $clog2(W),
  localparam int TOP = (LOG >= 2) ? (1 << (LOG - 2)) : 0
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);

  logic [W-1:0] prop0;
  logic [W-1:0] gp;   // group generate, prefix from bit 0 after both sweeps
  logic [W-1:0] pp;

  assign prop0 = x ^ y;

  always_comb begin
    gp = x & y;
    pp = prop0;
    // up-sweep: spans of 2d ending at i = k*2d - 1
    for (int d = 1; d < W; d = d * 2) begin
      for (int i = 0; i < W; i++) begin
        if ((i + 1) % (2 * d) == 0) begin
          gp[i] = gp[i] | (pp[i] & gp[i-d]);
          pp[i] = pp[i] & pp[i-d];
        end
      end
    end
    // down-sweep: fill the remaining prefixes
    for (int d = TOP; d > 0; d = d / 2) begin
      for (int i = 0; i < W; i++) begin
        if (((i + 1) % (2 * d) == d) && (i + 1 > d)) begin
          gp[i] = gp[i] | (pp[i] & gp[i-d]);
          pp[i] = pp[i] & pp[i-d];
        end
      end
    end
  end

  assign s = prop0 ^ {gp[W-2:0], 1'b0};

endmodule

// File: rtl/booth_mul.sv
module booth_mul #(
  parameter int A_W    = 12,
  parameter int B_W    = 9,
  parameter int STAGES = 1,
  localparam int W     = A_W + B_W,
  localparam int BE    = B_W + (B_W % 2),
  localparam int ROWS  = BE / 2 + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic [W-1:0]   prod
);

  logic [ROWS-1:0][W-1:0] pp_rows;
  logic [W-1:0] tree_sum;
  logic [W-1:0] tree_carry;
  logic [W-1:0] mid_sum;
  logic [W-1:0] mid_carry;
  logic [W-1:0] add_out;

  booth_pp_gen #(.A_W(A_W), .B_W(B_W)) u_pp (
    .a_in (a_in),
    .b_in (b_in),
    .rows (pp_rows)
  );

  csa_tree #(.W(W), .ROWS(ROWS)) u_tree (
    .rows_in (pp_rows),
    .sum_w   (tree_sum),
    .carry_w (tree_carry)
  );

  if (STAGES >= 1) begin : g_mid_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        mid_sum   <= '0;
        mid_carry <= '0;
      end else begin
        mid_sum   <= tree_sum;
        mid_carry <= tree_carry;
      end
    end
  end else begin : g_mid_wire
    assign mid_sum   = tree_sum;
    assign mid_carry = tree_carry;
  end

  bk_adder #(.W(W)) u_add (
    .x (mid_sum),
    .y (mid_carry),
    .s (add_out)
  );

  if (STAGES >= 2) begin : g_out_reg
    always_ff @(posedge clk) begin
      if (rst) prod <= '0;
      else     prod <= add_out;
    end
  end else begin : g_out_wire
    assign prod = add_out;
  end

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int A_W    = 12,
  parameter int B_W    = 9,
  parameter int STAGES = 1,
  localparam int W     = A_W + B_W
) (
  input logic           clk,
  input logic           rst,
  input logic [A_W-1:0] a_in,
  input logic [B_W-1:0] b_in,
  input logic [W-1:0]   tree_sum,
  input logic [W-1:0]   tree_carry,
  input logic [W-1:0]   mid_sum,
  input logic [W-1:0]   mid_carry,
  input logic [W-1:0]   prod
);

  logic signed [W-1:0] ref_now;
  logic [W-1:0]        words_now;
  logic [W-1:0]        mid_total;
  logic [1:0]          since;

  assign ref_now   = $signed(a_in) * $signed(b_in);
  assign words_now = tree_sum + tree_carry;
  assign mid_total = mid_sum + mid_carry;

  always_ff @(posedge clk) begin
    if (rst)              since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  assert_tree_words_R1: assert property (@(posedge clk) disable iff (rst)
    words_now == ref_now);

  if (STAGES == 2) begin : g_two
    assert_adder_R1: assert property (@(posedge clk) disable iff (rst)
      (since >= 2'd1) |-> prod == $past(mid_total));
    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
      (since >= 2'd2) |-> prod == $past(ref_now, 2));
  end else if (STAGES == 1) begin : g_one
    assert_adder_R1: assert property (@(posedge clk) disable iff (rst)
      prod == mid_total);
    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
      (since >= 2'd1) |-> prod == $past(ref_now));
  end else begin : g_zero
    assert_adder_R1: assert property (@(posedge clk) disable iff (rst)
      prod == mid_total);
    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
      prod == ref_now);
  end

  if (STAGES >= 1) begin : g_rst
    assert_reset_clear_R6: assert property (@(posedge clk)
      rst |=> prod == '0);
  end

endmodule

bind booth_mul booth_mul_chk #(.A_W(A_W), .B_W(B_W), .STAGES(STAGES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .a_in       (a_in),
  .b_in       (b_in),
  .tree_sum   (tree_sum),
  .tree_carry (tree_carry),
  .mid_sum    (mid_sum),
  .mid_carry  (mid_carry),
  .prod       (prod)
);

// File: tb/booth_mul_test.sv
module booth_mul_test;

  localparam int A_W = 12;
  localparam int B_W = 9;
  localparam int W   = A_W + B_W;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [A_W-1:0] a_in = '0;
  logic [B_W-1:0] b_in = '0;
  logic [W-1:0]   prod_s0;
  logic [W-1:0]   prod_s1;
  logic [W-1:0]   prod_s2;

  int total = 0;
  int bad   = 0;

  logic [W-1:0] h1 = '0;
  logic [W-1:0] h2 = '0;
  logic         v1 = 1'b0;
  logic         v2 = 1'b0;

  always #4 clk = ~clk;

  booth_mul #(.A_W(A_W), .B_W(B_W), .STAGES(0)) uut_s0 (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .prod(prod_s0));
  booth_mul #(.A_W(A_W), .B_W(B_W), .STAGES(1)) uut_s1 (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .prod(prod_s1));
  booth_mul #(.A_W(A_W), .B_W(B_W), .STAGES(2)) uut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .prod(prod_s2));

  function automatic logic [W-1:0] ref_mul(input logic [A_W-1:0] a,
                                           input logic [B_W-1:0] b);
    logic signed [W-1:0] ax;
    logic signed [W-1:0] bx;
    ax = W'($signed(a));
    bx = W'($signed(b));
    return ax * bx;
  endfunction

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp,
                     input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one operand pair; check the registered variants against history
  task automatic step(input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                      input string req);
    logic [W-1:0] e;
    e = ref_mul(a, b);
    @(negedge clk);
    if (v1) chk(prod_s1, h1, {req, " R5 one stage"});
    if (v2) chk(prod_s2, h2, {req, " R5 two stages"});
    h2 = h1; v2 = v1;
    h1 = e;  v1 = 1'b1;
    a_in = a; b_in = b;
    #1;
    chk(prod_s0, e, {req, " comb"});
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    a_in = 12'h5A3; b_in = 9'h0C7;
    @(negedge clk);
    chk(prod_s1, '0, "R6 one stage in reset");
    chk(prod_s2, '0, "R6 two stages in reset");
    a_in = 12'h7FF; b_in = 9'h100;
    @(negedge clk);
    chk(prod_s1, '0, "R6 one stage held");
    chk(prod_s2, '0, "R6 two stages held");
    rst = 1'b0;
    v1 = 1'b0; v2 = 1'b0;
  endtask

  task automatic t_extremes();
    step(12'h800, 9'h100, "R2 min*min");
    step(12'h800, 9'h0FF, "R2 min*max");
    step(12'h7FF, 9'h0FF, "R2 max*max");
    step(12'h7FF, 9'h100, "R2 max*min");
    step(12'h800, 9'h1FF, "R2 min*-1");
  endtask

  task automatic t_zero_one();
    step(12'h000, 9'h15B, "R3 zero a");
    step(12'h3C1, 9'h000, "R3 zero b");
    step(12'hFFF, 9'h0AB, "R3 a=-1");
    step(12'h2D4, 9'h1FF, "R3 b=-1");
    step(12'hFFF, 9'h1FF, "R3 -1*-1");
    step(12'h001, 9'h1FF, "R3 1*-1");
  endtask

  task automatic t_odd_width();
    step(12'h123, 9'h100, "R4 b top bit only");
    step(12'h123, 9'h0FF, "R4 b top bit clear");
    step(12'hA5C, 9'h180, "R4 b=-128");
    step(12'hA5C, 9'h17F, "R4 b=-129");
    step(12'h061, 9'h001, "R4 b=1");
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++) begin
      step(A_W'($urandom), B_W'($urandom), "R1 random");
    end
  endtask

  task automatic t_flush();
    step('0, '0, "R5 flush");
    step('0, '0, "R5 flush");
    step('0, '0, "R5 flush");
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_extremes();
    t_zero_one();
    t_odd_width();
    t_random();
    t_flush();
    // reset in mid-stream, then resume
    t_reset();
    t_extremes();
    t_flush();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule